// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This unit decides where a processor with 16-bit instructions fetches next. Each cycle it may accept one decoded control operation together with the address of that instruction, its immediate fields, one general-register value, the carry flag and a word read from memory. From these it works out the following program counter. The possible sources are straight-line flow, a carry-tested PC-relative branch, a jump through a register, a jump through a word in memory, a counted loop that branches backward, or one of four trap vectors. It also produces the side writes these operations need. Calls write the return address to the link register (register 15). The loop operation writes the decremented counter back. A trap hands the address of the following instruction to the exception logic.

The memory-read address for indirect and vector targets is driven combinationally in the same cycle as the operation, and the word that memory returns is expected on `mem_word_i` in that cycle. All other results are registered and appear one clock after the operation is accepted. Instructions are 2 bytes long, and relative displacements count instructions.

Top module: `next_pc_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `npc_vld_o`, `link_we_o`, `cnt_we_o` and `epc_we_o` are 0 and `npc_o` is 0.
- R2: `op_i` codes are 0 next, 1 relative, 2 relative-if-carry-set, 3 relative-if-carry-clear, 4 register jump, 5 indirect jump, 6 register call, 7 indirect call, 8 loop, 9 trap. Codes 10 to 15 act as code 0. For code 0, `npc_o` one cycle after acceptance equals `pc_i`+2.
- R3: For code 1, `npc_o` equals `pc_i`+2 plus twice the sign-extended 11-bit `disp11_i`, covering displacements from -1024 to +1023 instructions.
- R4: Code 2 takes the relative target only when `carry_i` is 1, and code 3 only when `carry_i` is 0. Otherwise `npc_o` is `pc_i`+2.
- R5: Codes 4 and 6 load `npc_o` from `rs_val_i`. Code 6, and code 7 as well, sets `link_we_o` with `link_data_o` = `pc_i`+2 as the value for register 15.
- R6: For codes 5 and 7, `mem_rd_req_o` is 1 in the same cycle with `mem_rd_addr_o` = ((`pc_i`+2) with bits 1:0 cleared) + 4×`disp8_i`, and `npc_o` then equals `mem_word_i`.
- R7: Code 8 always sets `cnt_we_o` with `cnt_data_o` = `rs_val_i`−1, wrapping modulo 2^32. When `carry_i` is 1, `npc_o` = `pc_i`+2 − 2×`loop_off_i` (4-bit unsigned). Otherwise `npc_o` = `pc_i`+2.
- R8: Code 9 requests memory at 0x40 + 4×`trap_idx_i`, which always lies within 0x40 to 0x4F. It loads `npc_o` from `mem_word_i` and sets `epc_we_o` with `epc_o` = `pc_i`+2.
- R9: When `op_valid_i` is 0, no memory read is requested. In the next cycle `npc_vld_o` and all write enables are 0 and `npc_o` keeps its value.
- R10: Results of an accepted operation appear exactly one clock later with `npc_vld_o` = 1, and at most one of the three write enables is 1 at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | A control operation is presented this cycle |
| op_i | input | 4 | Decoded control operation code |
| pc_i | input | 32 | Address of the current instruction |
| disp11_i | input | 11 | Signed relative displacement in instructions |
| disp8_i | input | 8 | Word displacement for indirect targets |
| loop_off_i | input | 4 | Backward loop distance in instructions |
| trap_idx_i | input | 2 | Trap vector index |
| rs_val_i | input | 32 | General-register operand value |
| mem_word_i | input | 32 | Word returned for the current memory read |
| carry_i | input | 1 | Carry flag |
| mem_rd_req_o | output | 1 | Memory read needed for the target |
| mem_rd_addr_o | output | 32 | Address of that read |
| npc_o | output | 32 | Next program counter |
| npc_vld_o | output | 1 | `npc_o` holds a fresh result |
| link_we_o | output | 1 | Write register 15 |
| link_data_o | output | 32 | Return address for register 15 |
| cnt_we_o | output | 1 | Write back the loop counter |
| cnt_data_o | output | 32 | Decremented loop counter |
| epc_we_o | output | 1 | Hand a return address to the exception logic |
| epc_o | output | 32 | Return address for the trap |

## Verification
Relative branches are tried with small positive and negative displacements and with both extremes of the 11-bit range, which exposes a missing sign extension or a missing shift by one. Each carry-tested form and the loop are run with carry at 0 and at 1, so an inverted or ignored condition gives a wrong target. Indirect targets are tried from a PC that is already word aligned and from one that is not, with the largest displacement, so a missing alignment mask or a wrong scale shows up. All four trap indices are used. Counter values of 0 and 5 show that the decrement wraps. An idle cycle after a taken jump shows that the held PC and the quiet enables do not come from a stale operation.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [3:0] {
    OP_NEXT    = 4'd0,
    OP_REL     = 4'd1,
    OP_REL_CS  = 4'd2,
    OP_REL_CC  = 4'd3,
    OP_JREG    = 4'd4,
    OP_JIND    = 4'd5,
    OP_CALLREG = 4'd6,
    OP_CALLIND = 4'd7,
    OP_DLOOP   = 4'd8,
    OP_TRAP    = 4'd9
  } npc_op_e;

  localparam int unsigned INSN_BYTES = 2;
endpackage

// File: rtl/npc_take_eval.sv
module npc_take_eval
  import npc_pkg::*;
(
  input  logic       vld_i,
  input  logic [3:0] op_i,
  input  logic       carry_i,
  output logic       use_rel_o,
  output logic       use_reg_o,
  output logic       use_mem_o,
  output logic       use_back_o,
  output logic       link_evt_o,
  output logic       loop_evt_o,
  output logic       trap_evt_o
);
  always_comb begin
    use_rel_o  = 1'b0;
    use_reg_o  = 1'b0;
    use_mem_o  = 1'b0;
    use_back_o = 1'b0;
    link_evt_o = 1'b0;
    loop_evt_o = 1'b0;
    trap_evt_o = 1'b0;
    if (vld_i) begin
      case (npc_op_e'(op_i))
        OP_REL:     use_rel_o = 1'b1;
        OP_REL_CS:  use_rel_o = carry_i;
        OP_REL_CC:  use_rel_o = !carry_i;
        OP_JREG:    use_reg_o = 1'b1;
        OP_CALLREG: begin use_reg_o = 1'b1; link_evt_o = 1'b1; end
        OP_JIND:    use_mem_o = 1'b1;
        OP_CALLIND: begin use_mem_o = 1'b1; link_evt_o = 1'b1; end
        OP_DLOOP:   begin loop_evt_o = 1'b1; use_back_o = carry_i; end
        OP_TRAP:    begin use_mem_o = 1'b1; trap_evt_o = 1'b1; end
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/npc_target_calc.sv
module npc_target_calc
  import npc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 11,
  parameter int unsigned IW = 8,
  parameter int unsigned LW = 4,
  parameter int unsigned TW = 2,
  parameter logic [AW-1:0] TRAP_BASE = 'h40
) (
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] disp_i,
  input  logic [IW-1:0] ind_i,
  input  logic [LW-1:0] off_i,
  input  logic [TW-1:0] idx_i,
  output logic [AW-1:0] seq_o,
  output logic [AW-1:0] rel_o,
  output logic [AW-1:0] back_o,
  output logic [AW-1:0] ind_addr_o,
  output logic [AW-1:0] vec_addr_o
);
  function automatic logic [AW-1:0] f_seq(input logic [AW-1:0] pc);
    return pc + AW'(INSN_BYTES);
  endfunction

  function automatic logic [AW-1:0] f_rel(input logic [AW-1:0] base,
                                          input logic [DW-1:0] d);
    logic [AW-1:0] ext;
    ext = {{(AW-DW){d[DW-1]}}, d};
    return base + (ext << 1);
  endfunction

  function automatic logic [AW-1:0] f_back(input logic [AW-1:0] base,
                                           input logic [LW-1:0] o);
    return base - (AW'(o) << 1);
  endfunction

  function automatic logic [AW-1:0] f_ind(input logic [AW-1:0] base,
                                          input logic [IW-1:0] d);
    return (base & ~AW'(3)) + (AW'(d) << 2);
  endfunction

  function automatic logic [AW-1:0] f_vec(input logic [TW-1:0] i);
    return TRAP_BASE + (AW'(i) << 2);
  endfunction

  always_comb begin
    seq_o      = f_seq(pc_i);
    rel_o      = f_rel(seq_o, disp_i);
    back_o     = f_back(seq_o, off_i);
    ind_addr_o = f_ind(seq_o, ind_i);
    vec_addr_o = f_vec(idx_i);
  end
endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
  import npc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 11,
  parameter int unsigned IW = 8,
  parameter int unsigned LW = 4,
  parameter int unsigned TW = 2,
  parameter logic [AW-1:0] TRAP_BASE = 'h40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid_i,
  input  logic [3:0]    op_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] disp11_i,
  input  logic [IW-1:0] disp8_i,
  input  logic [LW-1:0] loop_off_i,
  input  logic [TW-1:0] trap_idx_i,
  input  logic [AW-1:0] rs_val_i,
  input  logic [AW-1:0] mem_word_i,
  input  logic          carry_i,
  output logic          mem_rd_req_o,
  output logic [AW-1:0] mem_rd_addr_o,
  output logic [AW-1:0] npc_o,
  output logic          npc_vld_o,
  output logic          link_we_o,
  output logic [AW-1:0] link_data_o,
  output logic          cnt_we_o,
  output logic [AW-1:0] cnt_data_o,
  output logic          epc_we_o,
  output logic [AW-1:0] epc_o
);
  localparam logic [AW-1:0] VEC_LAST = TRAP_BASE + AW'(((1 << TW) - 1) * 4);

  logic use_rel, use_reg, use_mem, use_back;
  logic link_evt, loop_evt, trap_evt;
  logic [AW-1:0] seq_pc, rel_pc, back_pc, ind_addr, vec_addr, npc_d;

  npc_take_eval u_eval (
    .vld_i(op_valid_i), .op_i(op_i), .carry_i(carry_i),
    .use_rel_o(use_rel), .use_reg_o(use_reg), .use_mem_o(use_mem),
    .use_back_o(use_back), .link_evt_o(link_evt), .loop_evt_o(loop_evt),
    .trap_evt_o(trap_evt)
  );

  npc_target_calc #(
    .AW(AW), .DW(DW), .IW(IW), .LW(LW), .TW(TW), .TRAP_BASE(TRAP_BASE)
  ) u_calc (
    .pc_i(pc_i), .disp_i(disp11_i), .ind_i(disp8_i), .off_i(loop_off_i),
    .idx_i(trap_idx_i), .seq_o(seq_pc), .rel_o(rel_pc), .back_o(back_pc),
    .ind_addr_o(ind_addr), .vec_addr_o(vec_addr)
  );

  always_comb begin
    mem_rd_req_o  = use_mem;
    mem_rd_addr_o = trap_evt ? vec_addr : ind_addr;
    if (use_rel)       npc_d = rel_pc;
    else if (use_reg)  npc_d = rs_val_i;
    else if (use_mem)  npc_d = mem_word_i;
    else if (use_back) npc_d = back_pc;
    else               npc_d = seq_pc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      npc_o       <= '0;
      npc_vld_o   <= 1'b0;
      link_we_o   <= 1'b0;
      link_data_o <= '0;
      cnt_we_o    <= 1'b0;
      cnt_data_o  <= '0;
      epc_we_o    <= 1'b0;
      epc_o       <= '0;
    end else begin
      npc_vld_o <= op_valid_i;
      link_we_o <= link_evt;
      cnt_we_o  <= loop_evt;
      epc_we_o  <= trap_evt;
      if (op_valid_i) begin
        npc_o       <= npc_d;
        link_data_o <= seq_pc;
        cnt_data_o  <= rs_val_i - AW'(1);
        epc_o       <= seq_pc;
      end
    end
  end

  // R5 / R6: the return address belongs to the call accepted one edge earlier
  assert_link_ret_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> link_data_o == $past(pc_i) + AW'(2));

  // R7: counter write-back is the previous register value minus one
  assert_loop_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we_o |-> cnt_data_o == $past(rs_val_i) - AW'(1));

  // R8: vector reads stay inside the trap area and are word aligned
  assert_vec_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op_i == OP_TRAP) |->
      (mem_rd_req_o && mem_rd_addr_o >= TRAP_BASE &&
       mem_rd_addr_o <= VEC_LAST && mem_rd_addr_o[1:0] == 2'b00));

  // R4: carry-clear branch with carry set falls through
  assert_cc_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op_i == OP_REL_CC && carry_i) |=>
      npc_o == $past(pc_i) + AW'(2));

  // R9: an idle cycle leaves the PC alone and writes nothing
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |=> ($stable(npc_o) && !npc_vld_o && !link_we_o &&
                     !cnt_we_o && !epc_we_o));

  // R9: no memory traffic without an operation
  assert_idle_noread_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |-> !mem_rd_req_o);

  // R10: side writes are mutually exclusive
  assert_one_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({link_we_o, cnt_we_o, epc_we_o}));
endmodule

// File: tb/next_pc_unit_bench.sv
module next_pc_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] pc_i = '0;
  logic [10:0] disp11_i = '0;
  logic [7:0]  disp8_i = '0;
  logic [3:0]  loop_off_i = '0;
  logic [1:0]  trap_idx_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] mem_word_i = '0;
  logic        carry_i = 1'b0;
  logic        mem_rd_req_o, npc_vld_o, link_we_o, cnt_we_o, epc_we_o;
  logic [31:0] mem_rd_addr_o, npc_o, link_data_o, cnt_data_o, epc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  next_pc_unit u_next_pc_unit (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_i(op_i),
    .pc_i(pc_i), .disp11_i(disp11_i), .disp8_i(disp8_i),
    .loop_off_i(loop_off_i), .trap_idx_i(trap_idx_i), .rs_val_i(rs_val_i),
    .mem_word_i(mem_word_i), .carry_i(carry_i), .mem_rd_req_o(mem_rd_req_o),
    .mem_rd_addr_o(mem_rd_addr_o), .npc_o(npc_o), .npc_vld_o(npc_vld_o),
    .link_we_o(link_we_o), .link_data_o(link_data_o), .cnt_we_o(cnt_we_o),
    .cnt_data_o(cnt_data_o), .epc_we_o(epc_we_o), .epc_o(epc_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] e_rel(input logic [31:0] pc, input logic [10:0] d);
    return pc + 32'd2 + 32'($signed({d, 1'b0}));
  endfunction
  function automatic logic [31:0] e_back(input logic [31:0] pc, input logic [3:0] o);
    return pc + 32'd2 - {27'd0, o, 1'b0};
  endfunction
  function automatic logic [31:0] e_ind(input logic [31:0] pc, input logic [7:0] d);
    logic [31:0] s;
    s = pc + 32'd2;
    return {s[31:2], 2'b00} + {22'd0, d, 2'b00};
  endfunction

  // Present one operation at a falling edge; caller checks comb outputs, then calls settle
  task automatic present(input logic [3:0] op, input logic [31:0] pc,
                         input logic [31:0] rs, input logic [31:0] mw, input logic c);
    op_valid_i = 1'b1; op_i = op; pc_i = pc; rs_val_i = rs;
    mem_word_i = mw; carry_i = c;
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
    op_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "npc_vld", {31'd0, npc_vld_o}, 32'd0);
    chk("R1", "npc", npc_o, 32'd0);
    chk("R1", "enables", {29'd0, link_we_o, cnt_we_o, epc_we_o}, 32'd0);
  endtask

  task automatic t_sequential();
    present(4'd0, 32'h1000, 32'h0, 32'h0, 1'b1);
    chk("R2", "seq no read", {31'd0, mem_rd_req_o}, 32'd0);
    settle();
    chk("R2", "seq npc", npc_o, 32'h1002);
    chk("R10", "vld after op", {31'd0, npc_vld_o}, 32'd1);
    present(4'd12, 32'h3FFE, 32'h0, 32'h0, 1'b0);
    settle();
    chk("R2", "unused code npc", npc_o, 32'h4000);
  endtask

  task automatic t_relative();
    logic [10:0] d [4] = '{11'd5, 11'h7FF, 11'h400, 11'h3FF};
    logic [31:0] p [4] = '{32'h100, 32'h100, 32'h2000, 32'h2000};
    for (int i = 0; i < 4; i++) begin
      disp11_i = d[i];
      present(4'd1, p[i], 32'h0, 32'h0, 1'b0);
      settle();
      chk("R3", "rel npc", npc_o, e_rel(p[i], d[i]));
    end
  endtask

  task automatic t_conditional();
    disp11_i = 11'd20;
    for (int c = 0; c < 2; c++) begin
      present(4'd2, 32'h500, 32'h0, 32'h0, c[0]);
      settle();
      chk("R4", "brt npc", npc_o, c[0] ? e_rel(32'h500, 11'd20) : 32'h502);
      present(4'd3, 32'h600, 32'h0, 32'h0, c[0]);
      settle();
      chk("R4", "brf npc", npc_o, c[0] ? 32'h602 : e_rel(32'h600, 11'd20));
    end
  endtask

  task automatic t_register();
    present(4'd4, 32'h700, 32'hDEADBEE0, 32'h0, 1'b0);
    settle();
    chk("R5", "jmp npc", npc_o, 32'hDEADBEE0);
    chk("R5", "jmp no link", {31'd0, link_we_o}, 32'd0);
    present(4'd6, 32'h800, 32'h00CAFE00, 32'h0, 1'b0);
    settle();
    chk("R5", "call npc", npc_o, 32'h00CAFE00);
    chk("R5", "call link we", {31'd0, link_we_o}, 32'd1);
    chk("R5", "call link data", link_data_o, 32'h802);
  endtask

  task automatic t_indirect();
    disp8_i = 8'd3;
    present(4'd5, 32'h1006, 32'h0, 32'h00004444, 1'b0);
    chk("R6", "ind req", {31'd0, mem_rd_req_o}, 32'd1);
    chk("R6", "ind addr", mem_rd_addr_o, e_ind(32'h1006, 8'd3));
    settle();
    chk("R6", "ind npc", npc_o, 32'h00004444);
    disp8_i = 8'hFF;
    present(4'd7, 32'h1000, 32'h0, 32'h00008888, 1'b1);
    chk("R6", "call ind addr", mem_rd_addr_o, e_ind(32'h1000, 8'hFF));
    settle();
    chk("R6", "call ind npc", npc_o, 32'h00008888);
    chk("R6", "call ind link", link_data_o, 32'h1002);
    chk("R6", "call ind link we", {31'd0, link_we_o}, 32'd1);
  endtask

  task automatic t_loop();
    loop_off_i = 4'd15;
    present(4'd8, 32'h200, 32'd5, 32'h0, 1'b1);
    settle();
    chk("R7", "loop taken npc", npc_o, e_back(32'h200, 4'd15));
    chk("R7", "loop cnt", cnt_data_o, 32'd4);
    chk("R7", "loop cnt we", {31'd0, cnt_we_o}, 32'd1);
    loop_off_i = 4'd3;
    present(4'd8, 32'h300, 32'd0, 32'h0, 1'b0);
    settle();
    chk("R7", "loop fall npc", npc_o, 32'h302);
    chk("R7", "loop wrap cnt", cnt_data_o, 32'hFFFFFFFF);
    chk("R7", "loop fall cnt we", {31'd0, cnt_we_o}, 32'd1);
  endtask

  task automatic t_trap();
    for (int i = 0; i < 4; i++) begin
      trap_idx_i = 2'(i);
      present(4'd9, 32'h900 + 32'(i * 16), 32'h0, 32'hA000 + 32'(i), 1'b0);
      chk("R8", "vec req", {31'd0, mem_rd_req_o}, 32'd1);
      chk("R8", "vec addr", mem_rd_addr_o, 32'h40 | 32'(i * 4));
      settle();
      chk("R8", "trap npc", npc_o, 32'hA000 + 32'(i));
      chk("R8", "trap epc", epc_o, 32'h902 + 32'(i * 16));
      chk("R8", "trap epc we", {31'd0, epc_we_o}, 32'd1);
      chk("R10", "trap single write", {30'd0, link_we_o, cnt_we_o}, 32'd0);
    end
  endtask

  task automatic t_idle();
    present(4'd4, 32'h40, 32'h12345678, 32'h0, 1'b0);
    settle();
    op_i = 4'd6; pc_i = 32'hFFF0; rs_val_i = 32'h1; #1;
    chk("R9", "idle no read", {31'd0, mem_rd_req_o}, 32'd0);
    @(negedge clk);
    chk("R9", "idle npc held", npc_o, 32'h12345678);
    chk("R9", "idle vld", {31'd0, npc_vld_o}, 32'd0);
    chk("R9", "idle enables", {29'd0, link_we_o, cnt_we_o, epc_we_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sequential();
    t_relative();
    t_conditional();
    t_register();
    t_indirect();
    t_loop();
    t_trap();
    t_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule